// File: doc/BRIEF.md
# Per-Master Memory Access Protection Filter

This block sits between a multi-master interconnect and a memory controller and decides, request by request, whether the requesting master may go ahead. A single 32-bit control word holds a 2-bit permission code for each master. The code says whether that master may read, may write, may do both, or may do neither. Requests that are allowed pass straight through to the memory side in the same cycle. Requests that are refused never reach memory, and they are answered with an error pulse one cycle later.

The control word is reached through a small register port. Software may change a master's rights at run time. A change applies from the cycle after the write. The register takes only writes that cover the whole word. A write with any byte strobe clear is dropped. The bits above the permission fields are reserved and always read as ones.

Top module: `amp_filter`

## Requirements
- R1: After reset the control word reads 0xFFFFFFFF, and every master in range may both read and write.
- R2: Master m (0 to 3) takes its permission code from control bits [2m+1:2m]. Master 0 uses bits [1:0] and master 3 uses bits [7:6].
- R3: In a permission code, bit 0 grants reads and bit 1 grants writes. So 00 gives no access, 01 gives reads only, 10 gives writes only and 11 gives both.
- R4: Bits [31:8] of the control word always read as 1. Write data on those bits has no effect.
- R5: A register write with `reg_be` other than 4'b1111 is dropped, and the control word keeps its value.
- R6: A permitted request raises `mem_en` in the same cycle, with `mem_write`, `mem_addr` and `mem_mid` equal to the request's fields. `resp_err` stays low in the next cycle.
- R7: A refused request keeps `mem_en` low and raises `resp_err` for exactly the following cycle.
- R8: A request whose master ID is 4 or higher is refused.
- R9: A full-word write changes the decision for requests presented in the cycle right after the write's clock edge. A request presented in the same cycle as the write still uses the old code.
- R10: When `req_valid` is low, `mem_en` is low, and `resp_err` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_sel | input | 1 | Register port select |
| reg_wr | input | 1 | Register write strobe, taken at the clock edge while `reg_sel` is high |
| reg_be | input | 4 | Byte strobes of the register write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Current control word |
| req_valid | input | 1 | Request present |
| req_mid | input | 3 | ID of the requesting master |
| req_write | input | 1 | 1 for a write request, 0 for a read request |
| req_addr | input | 24 | Request address |
| mem_en | output | 1 | Request forwarded to memory |
| mem_write | output | 1 | Forwarded direction |
| mem_addr | output | 24 | Forwarded address |
| mem_mid | output | 3 | Forwarded master ID |
| resp_err | output | 1 | Error response for a request refused in the previous cycle |

## Verification
The bench builds the block with its default parameters: four masters and a 3-bit master ID. With a 3-bit ID, the out-of-range IDs 4 to 7 can be driven next to the valid ones. The bench loads all 256 possible permission bytes, each with random-looking reserved bits. Under each byte it presents a read and a write from every one of the eight IDs, so every code sits in every field position. It also sweeps all fifteen partial strobe patterns. Finally it steps through back-to-back write-then-request cycles to pin down when a new code takes effect.

// File: rtl/amp_pkg.sv
package amp_pkg;

  typedef enum logic [1:0] {
    PERM_NONE  = 2'b00,
    PERM_READ  = 2'b01,
    PERM_WRITE = 2'b10,
    PERM_BOTH  = 2'b11
  } perm_e;

  // bit 0 grants reads, bit 1 grants writes
  function automatic logic perm_allows(input logic [1:0] code, input logic is_write);
    return is_write ? code[1] : code[0];
  endfunction

endpackage

// File: rtl/amp_rst_sync.sv
module amp_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/amp_ctrl_reg.sv
module amp_ctrl_reg #(
  parameter int NUM_MASTERS = 4,
  parameter int REG_W       = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_req,
  input  logic [REG_W/8-1:0]   wr_be,
  input  logic [REG_W-1:0]     wr_data,
  output logic [2*NUM_MASTERS-1:0] perm_o,
  output logic [REG_W-1:0]     rd_data
);

  localparam int PERM_W = 2 * NUM_MASTERS;
  localparam int RSV_W  = REG_W - PERM_W;

  logic              full_word;
  logic              perm_en;
  logic [PERM_W-1:0] perm_d;
  logic [PERM_W-1:0] perm_q;

  assign full_word = &wr_be;
  assign perm_en   = wr_req & full_word;

  always_comb begin
    perm_d = perm_q;
    if (perm_en) begin
      perm_d = wr_data[PERM_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perm_q <= '1;
    end else if (perm_en) begin
      perm_q <= perm_d;
    end
  end

  assign perm_o  = perm_q;
  assign rd_data = {{RSV_W{1'b1}}, perm_q};

endmodule

// File: rtl/amp_decide.sv
module amp_decide #(
  parameter int NUM_MASTERS = 4,
  parameter int MID_W       = 3
) (
  input  logic [2*NUM_MASTERS-1:0] perm,
  input  logic                     valid,
  input  logic [MID_W-1:0]         mid,
  input  logic                     is_write,
  output logic                     grant,
  output logic                     deny
);

  import amp_pkg::*;

  logic [NUM_MASTERS-1:0] ok_vec;

  generate
    for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_master
      localparam logic [MID_W-1:0] MY_ID = MID_W'(m);
      assign ok_vec[m] = (mid == MY_ID) && perm_allows(perm[2*m +: 2], is_write);
    end
  endgenerate

  // IDs with no field never match, so they are refused
  assign grant = valid & (|ok_vec);
  assign deny  = valid & ~(|ok_vec);

endmodule

// File: rtl/amp_filter.sv
module amp_filter #(
  parameter int NUM_MASTERS = 4,
  parameter int MID_W       = 3,
  parameter int ADDR_W      = 24,
  parameter int REG_W       = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_sel,
  input  logic               reg_wr,
  input  logic [REG_W/8-1:0] reg_be,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic               req_valid,
  input  logic [MID_W-1:0]   req_mid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               mem_en,
  output logic               mem_write,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [MID_W-1:0]   mem_mid,
  output logic               resp_err
);

  localparam int PERM_W = 2 * NUM_MASTERS;

  logic              rst_n_int;
  logic [PERM_W-1:0] perm;
  logic              grant;
  logic              deny;
  logic              err_en;
  logic              err_d;
  logic              err_q;

  amp_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_int)
  );

  amp_ctrl_reg #(.NUM_MASTERS(NUM_MASTERS), .REG_W(REG_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_req  (reg_sel & reg_wr),
    .wr_be   (reg_be),
    .wr_data (reg_wdata),
    .perm_o  (perm),
    .rd_data (reg_rdata)
  );

  amp_decide #(.NUM_MASTERS(NUM_MASTERS), .MID_W(MID_W)) u_dec (
    .perm     (perm),
    .valid    (req_valid),
    .mid      (req_mid),
    .is_write (req_write),
    .grant    (grant),
    .deny     (deny)
  );

  assign err_en = deny | err_q;
  assign err_d  = deny;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      err_q <= 1'b0;
    end else if (err_en) begin
      err_q <= err_d;
    end
  end

  assign mem_en    = grant;
  assign mem_write = req_write;
  assign mem_addr  = req_addr;
  assign mem_mid   = req_mid;
  assign resp_err  = err_q;

endmodule

// File: rtl/amp_filter_chk.sv
module amp_filter_chk #(
  parameter int NUM_MASTERS = 4,
  parameter int MID_W       = 3,
  parameter int ADDR_W      = 24,
  parameter int REG_W       = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_sel,
  input logic               reg_wr,
  input logic [REG_W/8-1:0] reg_be,
  input logic [REG_W-1:0]   reg_rdata,
  input logic               req_valid,
  input logic [MID_W-1:0]   req_mid,
  input logic [ADDR_W-1:0]  req_addr,
  input logic               mem_en,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic               resp_err
);

  localparam int PERM_W = 2 * NUM_MASTERS;

  // R4
  rsv_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[REG_W-1:PERM_W] == '1);

  // R5
  partial_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && reg_wr && !(&reg_be)) |=> $stable(reg_rdata));

  // R6
  fwd_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (mem_addr == req_addr));

  // R6
  grant_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |=> !resp_err);

  // R7
  deny_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !mem_en) |=> resp_err);

  // R8
  bad_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (int'(req_mid) >= NUM_MASTERS)) |-> !mem_en);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !mem_en);

  // R10
  idle_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_err);

endmodule

bind amp_filter amp_filter_chk #(
  .NUM_MASTERS(NUM_MASTERS), .MID_W(MID_W), .ADDR_W(ADDR_W), .REG_W(REG_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_sel   (reg_sel),
  .reg_wr    (reg_wr),
  .reg_be    (reg_be),
  .reg_rdata (reg_rdata),
  .req_valid (req_valid),
  .req_mid   (req_mid),
  .req_addr  (req_addr),
  .mem_en    (mem_en),
  .mem_addr  (mem_addr),
  .resp_err  (resp_err)
);

// File: tb/amp_filter_tb.sv
module amp_filter_tb;

  logic        clk;
  logic        rst_n;
  logic        reg_sel;
  logic        reg_wr;
  logic [3:0]  reg_be;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        req_valid;
  logic [2:0]  req_mid;
  logic        req_write;
  logic [23:0] req_addr;
  logic        mem_en;
  logic        mem_write;
  logic [23:0] mem_addr;
  logic [2:0]  mem_mid;
  logic        resp_err;

  int n_checks = 0;
  int n_fail   = 0;
  logic done = 1'b0;

  amp_filter u_dut (
    .clk(clk), .rst_n(rst_n),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_mid(req_mid), .req_write(req_write),
    .req_addr(req_addr),
    .mem_en(mem_en), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_mid(mem_mid), .resp_err(resp_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected decision from R2, R3, R8
  function automatic logic expect_allow(input logic [7:0] cfg, input logic [2:0] mid,
                                        input logic wr);
    if (mid > 3'd3) return 1'b0;
    return wr ? cfg[2*mid+1] : cfg[2*mid];
  endfunction

  task automatic reg_write(input logic [31:0] data, input logic [3:0] be);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = data; reg_be = be;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic do_req(input logic [2:0] mid, input logic wr, input logic [23:0] addr,
                        input logic exp_ok, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_mid = mid; req_write = wr; req_addr = addr;
    #1;
    check(mem_en == exp_ok, {tag, " mem_en"}, 32'(mem_en), 32'(exp_ok));
    if (exp_ok)
      check(mem_addr == addr && mem_write == wr && mem_mid == mid,
            "R6 forward", {mem_mid, mem_write, 4'h0, mem_addr}, {mid, wr, 4'h0, addr});
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    check(resp_err == !exp_ok, {tag, " resp_err"}, 32'(resp_err), 32'(!exp_ok));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_sel = 1'b0; reg_wr = 1'b0; reg_be = 4'h0; reg_wdata = '0;
    req_valid = 1'b0; req_mid = '0; req_write = 1'b0; req_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(reg_rdata == 32'hFFFF_FFFF, "R1 reset value", reg_rdata, 32'hFFFF_FFFF);
    for (int m = 0; m < 4; m++) begin
      do_req(3'(m), 1'b0, 24'h000100 + 24'(m), 1'b1, "R1 reset read");
      do_req(3'(m), 1'b1, 24'h000200 + 24'(m), 1'b1, "R1 reset write");
    end

    // R10 idle: no enable, no error
    @(negedge clk); #1;
    check(mem_en == 1'b0, "R10 idle mem_en", 32'(mem_en), 32'h0);
    @(posedge clk); #1;
    check(resp_err == 1'b0, "R10 idle resp_err", 32'(resp_err), 32'h0);

    // R2 R3 R4 R8: all permission bytes, all IDs, both directions
    for (int cfg = 0; cfg < 256; cfg++) begin
      logic [31:0] wd;
      wd = {8'(cfg * 37 + 5), 8'(cfg ^ 8'h5A), 8'(~cfg), 8'(cfg)};
      reg_write(wd, 4'hF);
      check(reg_rdata == {24'hFFFFFF, 8'(cfg)}, "R4 readback", reg_rdata,
            {24'hFFFFFF, 8'(cfg)});
      for (int mid = 0; mid < 8; mid++) begin
        for (int wr = 0; wr < 2; wr++) begin
          do_req(3'(mid), 1'(wr), 24'(cfg * 16 + mid * 2 + wr),
                 expect_allow(8'(cfg), 3'(mid), 1'(wr)),
                 mid > 3 ? "R8 bad id" : "R3 R2 decision");
        end
      end
    end

    // R5 partial writes dropped
    reg_write(32'h0000_00C6, 4'hF);
    for (int be = 0; be < 15; be++) begin
      reg_write(32'h0000_0039, 4'(be));
      check(reg_rdata == 32'hFFFF_FFC6, "R5 partial drop", reg_rdata, 32'hFFFF_FFC6);
    end
    do_req(3'd1, 1'b0, 24'h00ABCD, 1'b1, "R5 decision kept");
    do_req(3'd0, 1'b0, 24'h00ABCE, 1'b0, "R5 decision kept");

    // R9 timing of an update
    reg_write(32'hFFFF_FFFF, 4'hF);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = 32'h0000_00FC; reg_be = 4'hF;
    req_valid = 1'b1; req_mid = 3'd0; req_write = 1'b0; req_addr = 24'h000777;
    #1;
    check(mem_en == 1'b1, "R9 same cycle old code", 32'(mem_en), 32'h1);
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
    #1;
    check(mem_en == 1'b0, "R9 next cycle new code", 32'(mem_en), 32'h0);
    @(posedge clk); #1;
    req_valid = 1'b0;
    check(resp_err == 1'b1, "R7 err after deny", 32'(resp_err), 32'h1);
    @(posedge clk); #1;
    check(resp_err == 1'b0, "R7 err one cycle", 32'(resp_err), 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule